// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading two levels of translation tables from memory. A request arrives on a valid/ready stream. The block latches the virtual address together with the root pointer of the directory, then fetches one directory entry and one table entry through a read port that allows one outstanding read. It reports either the assembled physical address or a fault that names the level that failed.

The virtual address has three fields. The top ten bits select a directory slot, the next ten bits select a slot in the second-level table, and the low twelve bits pass through unchanged as the byte offset. Every entry is one 32-bit word. Bit 0 of an entry is its present flag, and bits 31..12 hold a page-aligned physical frame. The block reads the directory first. If that entry is present, its frame is the base of the table that is read next. The frame from the table entry, joined with the offset, gives the result.

Back-pressure: `req_ready` is high only while the walker is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. The read request channel follows the same handshake, and the walker holds its address steady until the memory side accepts it. The response channel and the result have no ready signal. A response is taken in the cycle where `mem_rsp_valid` is high while a read is pending, and the result pulses for exactly one cycle.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle. A request offered while the walker is busy is not taken and has no effect on the current walk or on any later result.
- R2: The walker splits the latched virtual address into fields: bits 31..22 are the directory index, bits 21..12 are the table index, and bits 11..0 are the byte offset.
- R3: The first read goes to {root[31:12], 12'h000} + 4 × directory index. Bits 11..0 of `root_base` are ignored, and the root is sampled when the request is taken.
- R4: While `mem_rd_valid` is high and `mem_rd_ready` is low, `mem_rd_addr` and `mem_rd_valid` stay unchanged in the next cycle.
- R5: At most one read is outstanding. After a read is accepted, `mem_rd_valid` stays low until a response has been taken.
- R6: The second read goes to {dir_entry[31:12], 12'h000} + 4 × table index. Bits 11..1 of the directory entry are ignored.
- R7: If bit 0 of the directory entry is 0, no second read is issued. The result has fault=1, level=0, and paddr=0.
- R8: If bit 0 of the table entry is 0, the result has fault=1, level=1, and paddr=0.
- R9: If both entries are present, the result has fault=0 and paddr={table_entry[31:12], offset}.
- R10: `res_valid` is high for exactly one cycle per accepted request, and the walker is idle in the following cycle. On a fault, `res_fault_vaddr` equals the virtual address of that request.
- R11: The synchronous active-high reset returns the walker to idle, drops `mem_rd_valid` and `res_valid`, and clears all result outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 32 | Physical base of the directory; bits 11..0 ignored |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_paddr | output | 32 | Translated physical address (0 on fault) |
| res_fault | output | 1 | Translation failed on a clear present bit |
| res_fault_level | output | 1 | 0 = directory entry, 1 = table entry |
| res_fault_vaddr | output | 32 | Virtual address that faulted |

## Verification
The assertions check these properties on every cycle: the read address stays stable while the memory side stalls it, there is never a second read before a response arrives, the result strobe lasts one cycle and returns the walker to idle, a directory read carries the latched root frame, and a faulting result carries a zero address. Only the bench scenarios show that the right words are fetched and joined correctly: the worked example with indices 0x04e and 0x249, the extreme indices, ignored low bits in the root and in directory entries, faults at each level together with the number of reads issued, and requests offered while the walker is busy. Those scenarios run under random memory stalls and random response latency.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_DIR,
    ST_WAIT_DIR,
    ST_READ_PTE,
    ST_WAIT_PTE,
    ST_DONE
  } walk_state_e;

  localparam logic LVL_DIR = 1'b0;
  localparam logic LVL_TBL = 1'b1;
endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] vaddr,
  output logic [IDX_W-1:0]  dir_idx,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [OFF_W-1:0]  offset
);
  localparam int TBL_LO = OFF_W;
  localparam int DIR_LO = OFF_W + IDX_W;

  // R2: field boundaries 31..22 / 21..12 / 11..0 at default widths
  assign offset  = vaddr[OFF_W-1:0];
  assign tbl_idx = vaddr[TBL_LO +: IDX_W];
  assign dir_idx = vaddr[DIR_LO +: IDX_W];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 10,
  parameter int ENT_LOG = 2
) (
  input  logic [ADDR_W-OFF_W-1:0] frame,
  input  logic [IDX_W-1:0]        idx,
  output logic [ADDR_W-1:0]       addr
);
  localparam int PAD_W = ADDR_W - IDX_W - ENT_LOG;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] scaled;

  assign base   = {frame, {OFF_W{1'b0}}};
  assign scaled = {{PAD_W{1'b0}}, idx, {ENT_LOG{1'b0}}};
  assign addr   = base + scaled;
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_fire,
  input  logic        rd_fire,
  input  logic        rsp_valid,
  input  logic        present,
  output walk_state_e state
);
  walk_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (req_fire)  nxt = ST_READ_DIR;
      ST_READ_DIR: if (rd_fire)   nxt = ST_WAIT_DIR;
      ST_WAIT_DIR: if (rsp_valid) nxt = present ? ST_READ_PTE : ST_DONE;
      ST_READ_PTE: if (rd_fire)   nxt = ST_WAIT_PTE;
      ST_WAIT_PTE: if (rsp_valid) nxt = ST_DONE;
      ST_DONE:                    nxt = ST_IDLE;
      default:                    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R7: a directory miss never proceeds to a second fetch
  p_no_pte_after_miss_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_DIR && rsp_valid && !present) |=> state == ST_DONE);

  // R10: the done state lasts exactly one cycle
  p_done_once_r10: assert property (@(posedge clk) disable iff (rst)
    state == ST_DONE |=> state == ST_IDLE);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 10,
  parameter int ENT_LOG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_paddr,
  output logic              res_fault,
  output logic              res_fault_level,
  output logic [ADDR_W-1:0] res_fault_vaddr
);
  localparam int FRAME_W = ADDR_W - OFF_W;

  walk_state_e        state;
  logic [ADDR_W-1:0]  vaddr_q;
  logic [FRAME_W-1:0] root_frame_q;
  logic [FRAME_W-1:0] tbl_frame_q;
  logic [IDX_W-1:0]   dir_idx, tbl_idx, sel_idx;
  logic [OFF_W-1:0]   offset;
  logic [FRAME_W-1:0] sel_frame;
  logic [FRAME_W-1:0] ent_frame;
  logic               ent_present;
  logic               req_fire, rd_fire;
  logic               in_dir_wait, in_pte_wait;
  logic               unused_root_low;
  logic               unused_entry_mid;

  assign unused_root_low  = ^root_base[OFF_W-1:0];
  assign unused_entry_mid = ^mem_rsp_data[OFF_W-1:1];

  // Entry word layout: frame in the top bits, present flag in bit 0
  assign ent_frame   = mem_rsp_data[ADDR_W-1:OFF_W];
  assign ent_present = mem_rsp_data[0];

  assign req_ready    = (state == ST_IDLE);
  assign req_fire     = req_valid && req_ready;
  assign mem_rd_valid = (state == ST_READ_DIR) || (state == ST_READ_PTE);
  assign rd_fire      = mem_rd_valid && mem_rd_ready;
  assign res_valid    = (state == ST_DONE);
  assign in_dir_wait  = (state == ST_WAIT_DIR) && mem_rsp_valid;
  assign in_pte_wait  = (state == ST_WAIT_PTE) && mem_rsp_valid;

  pt_va_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
    .vaddr   (vaddr_q),
    .dir_idx (dir_idx),
    .tbl_idx (tbl_idx),
    .offset  (offset)
  );

  assign sel_frame = (state == ST_READ_PTE) ? tbl_frame_q : root_frame_q;
  assign sel_idx   = (state == ST_READ_PTE) ? tbl_idx : dir_idx;

  pt_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG(ENT_LOG)) u_eaddr (
    .frame (sel_frame),
    .idx   (sel_idx),
    .addr  (mem_rd_addr)
  );

  pt_walk_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_fire  (req_fire),
    .rd_fire   (rd_fire),
    .rsp_valid (mem_rsp_valid),
    .present   (ent_present),
    .state     (state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vaddr_q         <= '0;
      root_frame_q    <= '0;
      tbl_frame_q     <= '0;
      res_paddr       <= '0;
      res_fault       <= 1'b0;
      res_fault_level <= LVL_DIR;
      res_fault_vaddr <= '0;
    end else begin
      if (req_fire) begin
        vaddr_q         <= req_vaddr;
        root_frame_q    <= root_base[ADDR_W-1:OFF_W];
        res_paddr       <= '0;
        res_fault       <= 1'b0;
        res_fault_level <= LVL_DIR;
        res_fault_vaddr <= '0;
      end
      if (in_dir_wait) begin
        if (ent_present) begin
          tbl_frame_q <= ent_frame;
        end else begin
          res_fault       <= 1'b1;
          res_fault_level <= LVL_DIR;
          res_fault_vaddr <= vaddr_q;
          res_paddr       <= '0;
        end
      end
      if (in_pte_wait) begin
        if (ent_present) begin
          res_paddr <= {ent_frame, offset};
          res_fault <= 1'b0;
        end else begin
          res_fault       <= 1'b1;
          res_fault_level <= LVL_TBL;
          res_fault_vaddr <= vaddr_q;
          res_paddr       <= '0;
        end
      end
    end
  end

  // R4: stalled read keeps its address
  p_rd_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R5: an accepted read is never followed at once by another
  p_single_out_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

  // R3: directory read uses the latched root frame
  p_dir_root_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ_DIR) |-> (mem_rd_addr[ADDR_W-1:OFF_W] == root_frame_q));

  // R10: one-cycle strobe, idle afterwards
  p_res_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (!res_valid && req_ready));

  // R7/R8: faulting results carry no address
  p_fault_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |-> (res_paddr == '0));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] root_base;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        res_valid;
  logic [31:0] res_paddr;
  logic        res_fault;
  logic        res_fault_level;
  logic [31:0] res_fault_vaddr;

  always #4 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst(rst), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_paddr(res_paddr), .res_fault(res_fault),
    .res_fault_level(res_fault_level), .res_fault_vaddr(res_fault_vaddr)
  );

  typedef struct {
    logic [31:0] vaddr;
    logic [31:0] paddr;
    logic        fault;
    logic        level;
    int          reads;
  } exp_t;

  exp_t        sbq[$];
  logic [31:0] mem_model [bit [31:0]];
  int          checks = 0;
  int          fails  = 0;
  int          rd_count = 0;
  bit          finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_model.exists(a) ? mem_model[a] : 32'h0;
  endfunction

  // Memory responder: random accept stalls and random response latency
  initial begin
    logic [31:0] a;
    int lat;
    mem_rd_ready  = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_rd_ready = 1'b0;
      end else begin
        mem_rd_ready = ($urandom % 3) != 0;
        if (mem_rd_valid && mem_rd_ready) begin
          a = mem_rd_addr;
          rd_count++;
          @(negedge clk);
          mem_rd_ready = 1'b0;
          lat = $urandom % 3;
          repeat (lat) @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(a);
          @(negedge clk);
          mem_rsp_valid = 1'b0;
          mem_rsp_data  = $urandom;
        end
      end
    end
  end

  // Monitor: pop and compare each result
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && res_valid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R1", "unexpected result", res_paddr, 32'h0);
        end else begin
          e = sbq.pop_front();
          check(res_fault == e.fault, e.fault ? (e.level ? "R8" : "R7") : "R9",
                "fault flag", {31'h0, res_fault}, {31'h0, e.fault});
          check(res_paddr == e.paddr, e.fault ? "R7" : "R9", "paddr", res_paddr, e.paddr);
          if (e.fault) begin
            check(res_fault_level == e.level, e.level ? "R8" : "R7", "fault level",
                  {31'h0, res_fault_level}, {31'h0, e.level});
            check(res_fault_vaddr == e.vaddr, "R10", "fault vaddr", res_fault_vaddr, e.vaddr);
          end
          check(rd_count == e.reads, "R5", "reads per walk", rd_count, e.reads);
        end
        rd_count = 0;
        @(negedge clk);
        check(!res_valid && req_ready, "R10", "single-cycle strobe",
              {31'h0, res_valid}, 32'h0);
      end
    end
  end

  // Driver: compute the expected result from the memory image, then issue the request
  task automatic walk(input logic [31:0] va, input int noise);
    exp_t e;
    logic [31:0] pde, pte;
    // R2/R3: directory slot = root frame + 4*va[31:22]
    pde = rd({root_base[31:12], 12'h0} + {20'h0, va[31:22], 2'b00});
    e.vaddr = va;
    if (!pde[0]) begin
      e.fault = 1'b1; e.level = 1'b0; e.paddr = '0; e.reads = 1;
    end else begin
      // R6: table slot = pde frame + 4*va[21:12]
      pte = rd({pde[31:12], 12'h0} + {20'h0, va[21:12], 2'b00});
      e.reads = 2;
      if (!pte[0]) begin
        e.fault = 1'b1; e.level = 1'b1; e.paddr = '0;
      end else begin
        e.fault = 1'b0; e.level = 1'b0; e.paddr = {pte[31:12], va[11:0]};
      end
    end
    sbq.push_back(e);
    @(negedge clk);
    req_vaddr = va;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < noise; i++) begin
      req_vaddr = ~va;
      req_valid = 1'b1;
      check(!req_ready, "R1", "busy walker refuses request", {31'h0, req_ready}, 32'h0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!req_ready || sbq.size() != 0) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0;
    req_vaddr = '0;
    root_base = 32'h0001c000;
    repeat (4) @(negedge clk);
    // R11: reset state
    check(req_ready == 1'b1, "R11", "req_ready after reset", {31'h0, req_ready}, 32'h1);
    check(!mem_rd_valid && !res_valid, "R11", "strobes low in reset",
          {30'h0, mem_rd_valid, res_valid}, 32'h0);
    check(res_paddr == 0 && !res_fault && res_fault_vaddr == 0, "R11", "result cleared",
          res_paddr, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R9: worked example, indices 0x04e / 0x249
    mem_model[32'h0001c138] = 32'h000a2001;
    mem_model[32'h000a2924] = 32'h0341b001;
    walk(32'h13a49f01, 0);
    // R3: root low bits ignored
    root_base = 32'h0001cabc;
    walk(32'h13a49f01, 0);
    // R1: requests offered while busy
    walk(32'h13a49f01, 3);
    root_base = 32'h0001c000;

    // R7: directory entry absent (slot 0x04f empty)
    walk(32'h13e49f01, 0);
    // R8: table entry with present bit clear
    mem_model[32'h000a2928] = 32'h0777f000;
    walk(32'h13a4a123, 0);
    // R6: directory entry with junk in bits 11..1 but present
    mem_model[32'h0001c13c] = 32'h000b3ffF;
    mem_model[32'h000b3924] = 32'habcde001;
    walk(32'h13e49abc, 0);

    // Boundary indices: all zeros and all ones
    root_base = 32'h00200000;
    mem_model[32'h00200000] = 32'h00301001;
    mem_model[32'h00301000] = 32'h12345001;
    walk(32'h00000000, 0);
    mem_model[32'h00200ffc] = 32'h00402001;
    mem_model[32'h00402ffc] = 32'hfffff001;
    walk(32'hffffffff, 0);

    // Random walks over a sparse image
    root_base = 32'h00500000;
    for (int n = 0; n < 24; n++) begin
      logic [31:0] va, pde_a, tb;
      va    = $urandom;
      pde_a = 32'h00500000 + {20'h0, va[31:22], 2'b00};
      tb    = {12'h006, 8'($urandom), 12'h000};
      if (($urandom % 4) != 0) mem_model[pde_a] = tb | 32'h1;
      if (($urandom % 4) != 0)
        mem_model[tb + {20'h0, va[21:12], 2'b00}] = {20'($urandom), 11'h0, 1'b1};
      walk(va, n % 3);
    end

    repeat (6) @(negedge clk);
    check(sbq.size() == 0, "R10", "all results delivered", sbq.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule